// File: doc/BRIEF.md
# Dependent Instruction Pair Detector

This block looks at a short window of decoded instructions and picks pairs that a scheduler can treat as a single two-cycle unit. A pair is a value-producing head followed by a later tail that reads the head's result. Both must be single-cycle operations. The window holds eight slots and arrives as two beats of four lanes. After the second beat the block runs a fixed-length search. It then presents one pointer field per slot, together with a one-cycle valid strobe.

Eligibility is settled in one combinational pass over a dependence matrix built from the window. The pass applies the pairing rules: single-cycle class, nearest producer, taken-branch budget, operand budget, a conservative deadlock filter, and a late-operand veto. A sequential picker then walks the heads in slot order, one per cycle. Each head takes its nearest free tail, and both slots are then removed from further use. The front end would store the resulting pointers next to the instructions; that storage is not part of this block.

Top module: `fuse_pair_detect`

## Requirements
- R1: Lane j of the first accepted `in_valid` beat fills slot j and lane j of the second fills slot 4+j. `out_valid` is high for exactly one cycle, after the tenth rising edge that follows the edge capturing the second beat. `out_ptr` changes only on that edge and otherwise holds its value.
- R2: Only slots with both the valid flag and the single-cycle flag set may act as head or tail. Every other slot gets a zero pointer and is never pointed at.
- R3: A tail must read the head's destination in an enabled source, and the head must have its destination enabled. No valid slot strictly between them may write the same register.
- R4: The field of slot i is `out_ptr[4*i+3 : 4*i]`. Bit 3 is set when exactly one taken-branch flag lies among slots head through tail-1. Bits 2:0 hold the tail slot minus the head slot. The value 0000 means the slot heads no pair.
- R5: A candidate is rejected when two or more taken-branch flags lie among slots head through tail-1.
- R6: The number of distinct registers among the head's enabled sources and the tail's enabled sources must not exceed a limit. Tail sources equal to the head's destination are not counted. The limit is 2 when `mode_wide` is 0 and 3 when it is 1; `mode_wide` is sampled with the second beat.
- R7: A candidate (h,t) is rejected when some slot k with h<k<t depends on a slot in [h,k) and is depended on by a slot in (k,t]. Dependences here count every valid instruction, including multi-cycle ones.
- R8: A slot whose late-operand flag is set is never chosen as a tail. Its head may still pair with a later eligible slot.
- R9: Heads are served in ascending slot order, and each takes the nearest eligible tail not yet used. Every slot belongs to at most one pair.
- R10: `in_valid` beats that arrive between the capture of a second beat and the following `out_valid` are ignored. The next window again starts at slot 0.
- R11: While reset is held, `out_valid` is 0 and `out_ptr` is 0. The next beat after reset is taken as the first beat of a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A beat of four lanes is present |
| in_vld | input | 4 | Per-lane instruction valid |
| in_single | input | 4 | Per-lane single-cycle class flag |
| in_dst_en | input | 4 | Per-lane destination enable |
| in_dst | input | 20 | Per-lane destination register, 5 bits each |
| in_s0_en | input | 4 | Per-lane first source enable |
| in_s0 | input | 20 | Per-lane first source register |
| in_s1_en | input | 4 | Per-lane second source enable |
| in_s1 | input | 20 | Per-lane second source register |
| in_taken | input | 4 | Per-lane taken control transfer flag |
| in_late | input | 4 | Per-lane late-operand flag |
| mode_wide | input | 1 | Operand limit select: 0 for two, 1 for three |
| out_valid | output | 1 | Pointer set is ready (one-cycle strobe) |
| out_ptr | output | 32 | Eight 4-bit pair pointers, slot i at bits 4i+3:4i |

## Verification
The bench uses the default parameters: four lanes, two beats (an eight-slot window) and 5-bit register numbers. With these values, a 3-bit distance reaches the full span from slot 0 to slot 7, and a taken-branch scan or cycle filter can cover up to six intervening slots. Random windows draw register numbers from only four values. This makes multiple producers, redefinitions, competing tails and cycle-filter hits common, while directed windows pin down each rule and both operand-limit modes.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int REG_MAX_W = 8;
  typedef logic [REG_MAX_W-1:0] reg_id_t;

  typedef enum logic {PH_COLLECT, PH_SEARCH} phase_t;

  // number of distinct registers among the enabled entries of four
  function automatic logic [2:0] count_distinct(input logic [3:0] en,
                                                input reg_id_t r0, input reg_id_t r1,
                                                input reg_id_t r2, input reg_id_t r3);
    reg_id_t r [4];
    logic [2:0] n;
    logic seen;
    r[0] = r0; r[1] = r1; r[2] = r2; r[3] = r3;
    n = '0;
    for (int i = 0; i < 4; i++) begin
      seen = 1'b0;
      for (int j = 0; j < 4; j++)
        if (j < i && en[j] && r[j] == r[i]) seen = 1'b1;
      if (en[i] && !seen) n = n + 3'd1;
    end
    return n;
  endfunction
endpackage

// File: rtl/fuse_dep_matrix.sv
module fuse_dep_matrix
  import fuse_pkg::*;
#(
  parameter int WIN   = 8,
  parameter int REG_W = 5
) (
  input  logic [WIN-1:0]   vld,
  input  logic [WIN-1:0]   single,
  input  logic [WIN-1:0]   dst_en,
  input  logic [REG_W-1:0] dst [WIN],
  input  logic [WIN-1:0]   s0_en,
  input  logic [REG_W-1:0] s0 [WIN],
  input  logic [WIN-1:0]   s1_en,
  input  logic [REG_W-1:0] s1 [WIN],
  input  logic [WIN-1:0]   taken,
  input  logic [WIN-1:0]   late,
  input  logic             mode_wide,
  output logic [WIN-1:0]   elig [WIN],
  output logic [WIN-1:0]   ctl  [WIN]
);
  logic [WIN-1:0] dep [WIN];   // dep[a][b]: b consumes the value a produces

  always_comb begin
    for (int a = 0; a < WIN; a++) begin
      for (int b = 0; b < WIN; b++) begin
        logic rd, redef;
        rd    = 1'b0;
        redef = 1'b0;
        dep[a][b] = 1'b0;
        if (b > a && vld[a] && vld[b] && dst_en[a]) begin
          rd = (s0_en[b] && s0[b] == dst[a]) || (s1_en[b] && s1[b] == dst[a]);
          for (int k = 0; k < WIN; k++)
            if (k > a && k < b && vld[k] && dst_en[k] && dst[k] == dst[a]) redef = 1'b1;
          dep[a][b] = rd && !redef;
        end
      end
    end
  end

  always_comb begin
    for (int h = 0; h < WIN; h++) begin
      for (int t = 0; t < WIN; t++) begin
        logic one_br, two_br, loop_risk, has_in, has_out;
        logic [2:0] nsrc, lim;
        one_br = 1'b0; two_br = 1'b0; loop_risk = 1'b0;
        has_in = 1'b0; has_out = 1'b0;
        nsrc = '0;
        lim = mode_wide ? 3'd3 : 3'd2;
        elig[h][t] = 1'b0;
        ctl[h][t]  = 1'b0;
        if (t > h && dep[h][t] && single[h] && single[t] && !late[t]) begin
          for (int k = 0; k < WIN; k++)
            if (k >= h && k < t && vld[k] && taken[k]) begin
              if (one_br) two_br = 1'b1;
              one_br = 1'b1;
            end
          nsrc = count_distinct({s1_en[t] && s1[t] != dst[h], s0_en[t] && s0[t] != dst[h],
                                 s1_en[h], s0_en[h]},
                                reg_id_t'(s0[h]), reg_id_t'(s1[h]),
                                reg_id_t'(s0[t]), reg_id_t'(s1[t]));
          for (int k = 0; k < WIN; k++) begin
            has_in  = 1'b0;
            has_out = 1'b0;
            if (k > h && k < t) begin
              for (int j = 0; j < WIN; j++) begin
                if (j >= h && j < k && dep[j][k]) has_in = 1'b1;
                if (j > k && j <= t && dep[k][j]) has_out = 1'b1;
              end
              if (has_in && has_out) loop_risk = 1'b1;
            end
          end
          elig[h][t] = !two_br && (nsrc <= lim) && !loop_risk;
          ctl[h][t]  = one_br;
        end
      end
    end
  end
endmodule

// File: rtl/fuse_pair_picker.sv
module fuse_pair_picker #(
  parameter int WIN   = 8,
  localparam int DW    = $clog2(WIN),
  localparam int PTR_W = DW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIN-1:0]   elig [WIN],
  input  logic [WIN-1:0]   ctl  [WIN],
  output logic [PTR_W-1:0] ptr  [WIN],
  output logic             fin
);
  logic           running;
  logic [DW-1:0]  step;
  logic [WIN-1:0] used;
  logic           found;
  logic [DW-1:0]  tsel;

  // priority decode: nearest free eligible tail for the current head
  always_comb begin
    found = 1'b0;
    tsel  = '0;
    for (int t = WIN - 1; t >= 0; t--)
      if (t > int'(step) && elig[step][t] && !used[t]) begin
        found = 1'b1;
        tsel  = DW'(t);
      end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      step    <= '0;
      used    <= '0;
      fin     <= 1'b0;
      for (int i = 0; i < WIN; i++) ptr[i] <= '0;
    end else begin
      fin <= 1'b0;
      if (start) begin
        running <= 1'b1;
        step    <= '0;
        used    <= '0;
        for (int i = 0; i < WIN; i++) ptr[i] <= '0;
      end else if (running) begin
        if (!used[step] && found) begin
          used[step] <= 1'b1;
          used[tsel] <= 1'b1;
          ptr[step]  <= {ctl[step][tsel], tsel - step};
        end
        if (step == DW'(WIN - 1)) begin
          running <= 1'b0;
          fin     <= 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  AST_USED_KEPT: assert property (@(posedge clk) disable iff (rst)
    running |=> ((used & $past(used)) == $past(used))); // R9
  AST_PAIR_STEP: assert property (@(posedge clk) disable iff (rst)
    running |=> ($countones(used) == $countones($past(used))) ||
                ($countones(used) == $countones($past(used)) + 2)); // R9
endmodule

// File: rtl/fuse_pair_detect.sv
module fuse_pair_detect
  import fuse_pkg::*;
#(
  parameter int LANES = 4,
  parameter int BEATS = 2,
  parameter int REG_W = 5,
  localparam int WIN   = LANES * BEATS,
  localparam int DW    = $clog2(WIN),
  localparam int PTR_W = DW + 1,
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [LANES-1:0]       in_vld,
  input  logic [LANES-1:0]       in_single,
  input  logic [LANES-1:0]       in_dst_en,
  input  logic [LANES*REG_W-1:0] in_dst,
  input  logic [LANES-1:0]       in_s0_en,
  input  logic [LANES*REG_W-1:0] in_s0,
  input  logic [LANES-1:0]       in_s1_en,
  input  logic [LANES*REG_W-1:0] in_s1,
  input  logic [LANES-1:0]       in_taken,
  input  logic [LANES-1:0]       in_late,
  input  logic                   mode_wide,
  output logic                   out_valid,
  output logic [WIN*PTR_W-1:0]   out_ptr
);
  phase_t         phase;
  logic [BW-1:0]  beat;
  logic           start;
  logic           mode_q;
  logic [WIN-1:0] win_vld, win_single, win_dst_en, win_s0_en, win_s1_en, win_taken, win_late;
  logic [REG_W-1:0] win_dst [WIN];
  logic [REG_W-1:0] win_s0  [WIN];
  logic [REG_W-1:0] win_s1  [WIN];
  logic [WIN-1:0]   elig [WIN];
  logic [WIN-1:0]   ctl  [WIN];
  logic [PTR_W-1:0] pick_ptr [WIN];
  logic             pick_fin;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_COLLECT;
      beat      <= '0;
      start     <= 1'b0;
      mode_q    <= 1'b0;
      out_valid <= 1'b0;
      out_ptr   <= '0;
      win_vld <= '0; win_single <= '0; win_dst_en <= '0;
      win_s0_en <= '0; win_s1_en <= '0; win_taken <= '0; win_late <= '0;
      for (int i = 0; i < WIN; i++) begin
        win_dst[i] <= '0; win_s0[i] <= '0; win_s1[i] <= '0;
      end
    end else begin
      start     <= 1'b0;
      out_valid <= 1'b0;
      if (phase == PH_COLLECT && in_valid) begin
        for (int j = 0; j < LANES; j++) begin
          win_vld[int'(beat)*LANES + j]    <= in_vld[j];
          win_single[int'(beat)*LANES + j] <= in_single[j];
          win_dst_en[int'(beat)*LANES + j] <= in_dst_en[j];
          win_s0_en[int'(beat)*LANES + j]  <= in_s0_en[j];
          win_s1_en[int'(beat)*LANES + j]  <= in_s1_en[j];
          win_taken[int'(beat)*LANES + j]  <= in_taken[j];
          win_late[int'(beat)*LANES + j]   <= in_late[j];
          win_dst[int'(beat)*LANES + j]    <= in_dst[j*REG_W +: REG_W];
          win_s0[int'(beat)*LANES + j]     <= in_s0[j*REG_W +: REG_W];
          win_s1[int'(beat)*LANES + j]     <= in_s1[j*REG_W +: REG_W];
        end
        if (beat == BW'(BEATS - 1)) begin
          beat   <= '0;
          phase  <= PH_SEARCH;
          start  <= 1'b1;
          mode_q <= mode_wide;
        end else begin
          beat <= beat + 1'b1;
        end
      end
      if (pick_fin) begin
        out_valid <= 1'b1;
        phase     <= PH_COLLECT;
        for (int i = 0; i < WIN; i++) out_ptr[i*PTR_W +: PTR_W] <= pick_ptr[i];
      end
    end
  end

  fuse_dep_matrix #(.WIN(WIN), .REG_W(REG_W)) u_matrix (
    .vld(win_vld), .single(win_single), .dst_en(win_dst_en), .dst(win_dst),
    .s0_en(win_s0_en), .s0(win_s0), .s1_en(win_s1_en), .s1(win_s1),
    .taken(win_taken), .late(win_late), .mode_wide(mode_q),
    .elig(elig), .ctl(ctl)
  );

  fuse_pair_picker #(.WIN(WIN)) u_picker (
    .clk(clk), .rst(rst), .start(start), .elig(elig), .ctl(ctl),
    .ptr(pick_ptr), .fin(pick_fin)
  );

  // tail_hit[t][h]: slot h points at slot t
  logic [WIN-1:0] tail_hit [WIN];
  always_comb begin
    for (int t = 0; t < WIN; t++)
      for (int h = 0; h < WIN; h++)
        tail_hit[t][h] = (h < t) && (out_ptr[h*PTR_W +: DW] == DW'(t - h));
  end

  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid); // R1
  AST_PTR_HELD: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_ptr)); // R1

  for (genvar gi = 0; gi < WIN; gi++) begin : g_chk
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_valid && (out_ptr[gi*PTR_W +: DW] != '0) |->
        (gi + int'(out_ptr[gi*PTR_W +: DW])) < WIN); // R4
    AST_HEAD_CLASS: assert property (@(posedge clk) disable iff (rst)
      out_valid && (out_ptr[gi*PTR_W +: DW] != '0) |-> win_vld[gi] && win_single[gi]); // R2
    AST_TAIL_ONCE: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $countones(tail_hit[gi]) <= 1); // R9
  end
endmodule

// File: tb/sim_fuse_pair_detect.sv
module sim_fuse_pair_detect;
  localparam int LANES = 4, BEATS = 2, RW = 5, WIN = 8, PW = 4, LAT = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, mode_wide = 1'b0;
  logic [LANES-1:0] in_vld = '0, in_single = '0, in_dst_en = '0, in_s0_en = '0, in_s1_en = '0;
  logic [LANES-1:0] in_taken = '0, in_late = '0;
  logic [LANES*RW-1:0] in_dst = '0, in_s0 = '0, in_s1 = '0;
  logic out_valid;
  logic [WIN*PW-1:0] out_ptr;

  always #10 clk = ~clk;

  fuse_pair_detect u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vld(in_vld), .in_single(in_single),
    .in_dst_en(in_dst_en), .in_dst(in_dst), .in_s0_en(in_s0_en), .in_s0(in_s0),
    .in_s1_en(in_s1_en), .in_s1(in_s1), .in_taken(in_taken), .in_late(in_late),
    .mode_wide(mode_wide), .out_valid(out_valid), .out_ptr(out_ptr)
  );

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic w_v[WIN], w_sc[WIN], w_de[WIN], w_e0[WIN], w_e1[WIN], w_tk[WIN], w_lt[WIN];
  logic [RW-1:0] w_d[WIN], w_a[WIN], w_b[WIN];
  logic [WIN*PW-1:0] exp_q[$];
  int due_q[$];
  string tag_q[$];
  logic [WIN*PW-1:0] last_exp;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_win();
    for (int i = 0; i < WIN; i++) begin
      w_v[i] = 0; w_sc[i] = 0; w_de[i] = 0; w_e0[i] = 0; w_e1[i] = 0;
      w_tk[i] = 0; w_lt[i] = 0; w_d[i] = '0; w_a[i] = '0; w_b[i] = '0;
    end
  endtask

  // slot, single, dst (0 = none), src a (0 = none), src b (0 = none), taken, late
  task automatic put(input int i, input bit sc, input int d, input int a, input int b,
                     input bit tk, input bit lt);
    w_v[i] = 1; w_sc[i] = sc; w_tk[i] = tk; w_lt[i] = lt;
    w_de[i] = (d != 0); w_d[i] = RW'(d);
    w_e0[i] = (a != 0); w_a[i] = RW'(a);
    w_e1[i] = (b != 0); w_b[i] = RW'(b);
  endtask

  // reference: greedy pairing written from the requirements
  function automatic logic [WIN*PW-1:0] model(input logic wide);
    logic [WIN-1:0] prod [WIN];   // prod[b][a]: b takes a value from a
    logic [WIN-1:0] used;
    logic [WIN*PW-1:0] res;
    for (int b = 0; b < WIN; b++) prod[b] = '0;
    for (int b = 0; b < WIN; b++) begin
      if (!w_v[b]) continue;
      for (int s = 0; s < 2; s++) begin
        logic en; logic [RW-1:0] r;
        en = (s == 0) ? w_e0[b] : w_e1[b];
        r  = (s == 0) ? w_a[b] : w_b[b];
        if (!en) continue;
        for (int a = b - 1; a >= 0; a--)
          if (w_v[a] && w_de[a] && w_d[a] == r) begin prod[b][a] = 1; break; end
      end
    end
    used = '0; res = '0;
    for (int h = 0; h < WIN; h++) begin
      if (used[h]) continue;
      for (int t = h + 1; t < WIN; t++) begin
        int nbr; logic [31:0] regs; bit risky;
        if (used[t] || !w_sc[h] || !w_sc[t] || !prod[t][h] || w_lt[t]) continue;
        nbr = 0;
        for (int k = h; k < t; k++) if (w_v[k] && w_tk[k]) nbr++;
        if (nbr > 1) continue;
        regs = '0;
        if (w_e0[h]) regs[w_a[h]] = 1;
        if (w_e1[h]) regs[w_b[h]] = 1;
        if (w_e0[t] && w_a[t] != w_d[h]) regs[w_a[t]] = 1;
        if (w_e1[t] && w_b[t] != w_d[h]) regs[w_b[t]] = 1;
        if ($countones(regs) > (wide ? 3 : 2)) continue;
        risky = 0;
        for (int k = h + 1; k < t; k++) begin
          bit fin_in, fin_out;
          fin_in = 0; fin_out = 0;
          for (int j = h; j < k; j++) if (prod[k][j]) fin_in = 1;
          for (int j = k + 1; j <= t; j++) if (prod[j][k]) fin_out = 1;
          if (fin_in && fin_out) risky = 1;
        end
        if (risky) continue;
        used[h] = 1; used[t] = 1;
        res[h*PW +: PW] = {(nbr == 1), 3'(t - h)};
        break;
      end
    end
    return res;
  endfunction

  task automatic drive_beat(input int bt);
    for (int j = 0; j < LANES; j++) begin
      int s; s = bt * LANES + j;
      in_vld[j] = w_v[s]; in_single[j] = w_sc[s]; in_dst_en[j] = w_de[s];
      in_s0_en[j] = w_e0[s]; in_s1_en[j] = w_e1[s]; in_taken[j] = w_tk[s]; in_late[j] = w_lt[s];
      in_dst[j*RW +: RW] = w_d[s]; in_s0[j*RW +: RW] = w_a[s]; in_s1[j*RW +: RW] = w_b[s];
    end
  endtask

  task automatic run_window(input logic wide, input string tag, input bit poke);
    logic [WIN*PW-1:0] e;
    e = model(wide);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); drive_beat(0); in_valid = 1; mode_wide = wide;
    @(negedge clk); drive_beat(1); due_q.push_back(cyc + LAT + 1);
    @(negedge clk); in_valid = 0; mode_wide = ~wide;
    if (poke) begin
      repeat (3) @(negedge clk);
      in_vld = '1; in_single = '1; in_dst_en = '1; in_s0_en = '1; in_dst = '1; in_s0 = '1;
      in_valid = 1;
      @(negedge clk); in_valid = 0;
    end
    repeat (LAT + 4) @(negedge clk);
    last_exp = e;
  endtask

  // monitor: scoreboard side
  initial begin
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (exp_q.size() == 0) chk(0, "R1 unexpected strobe", 64'(out_ptr), 0);
        else begin
          logic [WIN*PW-1:0] e; int d; string tg;
          e = exp_q.pop_front(); d = due_q.pop_front(); tg = tag_q.pop_front();
          chk(out_ptr == e, tg, 64'(out_ptr), 64'(e));
          chk(cyc == d, "R1 strobe cycle", 64'(cyc), 64'(d));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0, "R11 reset strobe", 64'(out_valid), 0);
    chk(out_ptr == '0, "R11 reset ptr", 64'(out_ptr), 0);
    rst = 0;

    clear_win(); put(0, 1, 1, 2, 3, 0, 0); put(1, 1, 6, 1, 0, 0, 0);
    run_window(0, "R3 R4 basic pair", 0);
    chk(last_exp[3:0] == 4'b0001, "R4 model basic", 64'(last_exp), 64'h1);

    clear_win(); put(0, 0, 1, 0, 0, 0, 0); put(1, 1, 6, 1, 0, 0, 0);
    put(2, 1, 4, 5, 0, 0, 0); put(3, 1, 7, 4, 0, 0, 0);
    run_window(0, "R2 multi-cycle head excluded", 0);
    chk(last_exp == 32'h0000_0100, "R2 model", 64'(last_exp), 64'h100);

    clear_win(); put(0, 1, 1, 0, 0, 0, 0); put(1, 1, 1, 6, 0, 0, 0); put(2, 1, 8, 1, 0, 0, 0);
    run_window(0, "R3 nearest producer", 0);
    chk(last_exp == 32'h0000_0010, "R3 model", 64'(last_exp), 64'h10);

    clear_win(); put(0, 1, 1, 0, 0, 0, 0); put(1, 1, 0, 7, 0, 1, 0); put(2, 1, 9, 1, 0, 0, 0);
    put(4, 1, 2, 0, 0, 0, 0); put(5, 1, 0, 0, 0, 1, 0); put(6, 1, 0, 0, 0, 1, 0);
    put(7, 1, 3, 2, 0, 0, 0);
    run_window(0, "R4 R5 branch budget", 0);
    chk(last_exp == 32'h0000_000a, "R5 model", 64'(last_exp), 64'ha);

    clear_win(); put(0, 1, 1, 2, 3, 0, 0); put(1, 1, 6, 1, 4, 0, 0);
    put(2, 1, 5, 2, 3, 0, 0); put(3, 1, 7, 5, 2, 0, 0);
    run_window(0, "R6 limit two", 0);
    chk(last_exp == 32'h0000_0100, "R6 model narrow", 64'(last_exp), 64'h100);
    run_window(1, "R6 limit three", 0);
    chk(last_exp == 32'h0000_0101, "R6 model wide", 64'(last_exp), 64'h101);

    clear_win(); put(0, 1, 1, 0, 0, 0, 0); put(1, 0, 2, 1, 0, 0, 0); put(2, 1, 3, 1, 2, 0, 0);
    run_window(0, "R7 cycle filter", 0);
    chk(last_exp == '0, "R7 model", 64'(last_exp), 0);

    clear_win(); put(0, 1, 1, 0, 0, 0, 0); put(1, 1, 6, 1, 0, 0, 1); put(2, 1, 7, 1, 0, 0, 0);
    run_window(0, "R8 late tail skipped", 0);
    chk(last_exp == 32'h0000_0002, "R8 model", 64'(last_exp), 64'h2);

    clear_win(); put(0, 1, 1, 0, 0, 0, 0); put(1, 1, 2, 1, 0, 0, 0); put(2, 1, 0, 1, 0, 0, 0);
    put(3, 1, 3, 0, 0, 0, 0); put(4, 1, 4, 3, 0, 0, 0); put(5, 1, 0, 4, 0, 0, 0);
    run_window(0, "R9 greedy nearest", 0);
    chk(last_exp == 32'h0000_1001, "R9 model", 64'(last_exp), 64'h1001);

    clear_win(); put(0, 1, 1, 2, 3, 0, 0); put(1, 1, 6, 1, 0, 0, 0);
    run_window(0, "R10 busy beat ignored", 1);
    clear_win(); put(4, 1, 2, 0, 0, 0, 0); put(7, 1, 9, 2, 0, 0, 0);
    run_window(0, "R10 next window aligned", 0);
    repeat (3) @(negedge clk);
    chk(out_ptr == last_exp, "R1 pointer held", 64'(out_ptr), 64'(last_exp));

    for (int n = 0; n < 60; n++) begin
      clear_win();
      for (int i = 0; i < WIN; i++) begin
        if ($urandom_range(7) == 0) continue;
        put(i, $urandom_range(4) != 0, $urandom_range(3) == 0 ? 0 : $urandom_range(1, 4),
            $urandom_range(4), $urandom_range(2) == 0 ? $urandom_range(4) : 0,
            $urandom_range(5) == 0, $urandom_range(7) == 0);
      end
      run_window(1'($urandom_range(1)), "R9 random window", 0);
    end

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all windows answered", 64'(exp_q.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule